// File: doc/BRIEF.md
# Short-Opcode Wide Control Word Expander

This block turns a compact 16-bit instruction into a 96-bit control word that can steer several functional units in the same cycle. The low byte of an expansion instruction selects one of up to 256 programmable entries in an on-chip RAM. The selected entry is presented, one clock later, as a parallel control word. The instruction set can then be reshaped for an application by loading new table contents rather than by changing decode logic.

An instruction is an expansion instruction only when its upper byte matches a fixed prefix. Any other instruction leaves the control output invalid and unchanged. A host write port can replace entries while instructions are streaming. If a write and a lookup hit the same entry in the same cycle, the lookup returns the contents that were there before the write. The top four bits of every entry are reserved for an attached application-specific execution unit, and they also appear on their own output.

Top module: `wcw_expander`

## Requirements
- R1: While reset is held and in the first cycle after it, `ctl_valid` is 0 and `ctl_word` and `acc_ctl` are all zeros.
- R2: An instruction with `instr_valid` high and `instr[15:8]` equal to the prefix 8'hA5 sets `ctl_valid` high in the following cycle.
- R3: In the cycle after an instruction whose upper byte differs from 8'hA5, or after a cycle with `instr_valid` low, `ctl_valid` is 0.
- R4: In the cycle after an expansion instruction, `ctl_word` equals the table entry selected by `instr[7:0]`. Lookups on consecutive cycles each return their own entry.
- R5: `acc_ctl` carries bits [95:92] of the entry returned by the most recent lookup.
- R6: When a write and a lookup address the same entry in the same cycle, the lookup returns the entry's contents from before that write.
- R7: A write at cycle t is returned by any lookup of that index issued at cycle t+1 or later. Entries can be replaced at any time outside reset.
- R8: A write to one index leaves every other entry unchanged.
- R9: While no lookup is issued, `ctl_word` and `acc_ctl` keep the values from the last lookup, even when the table is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction strobe |
| instr | input | 16 | Instruction: prefix in [15:8], table index in [7:0] |
| wr_en | input | 1 | Table write enable |
| wr_idx | input | 8 | Entry to write |
| wr_data | input | 96 | New entry contents |
| ctl_valid | output | 1 | Control word valid, one cycle after an expansion instruction |
| ctl_word | output | 96 | Expanded control word |
| acc_ctl | output | 4 | Accelerator control field, bits [95:92] of the entry |

## Verification
On every cycle, the embedded assertions check that `ctl_valid` follows the prefix match (R2, R3), that the output word holds when there is no lookup (R9), and that a write followed by a lookup of the same entry returns the written data (R7). The exact data returned by lookups (R4, R5) can only be shown by the directed scenarios, which compare the outputs with a model of the table held in the bench. The same applies to the same-cycle read-before-write ordering (R6) and to the isolation of neighbouring entries (R8).

// File: rtl/wcw_pkg.sv
package wcw_pkg;
   localparam int unsigned DEF_INSTR_W = 16;
   localparam int unsigned DEF_IDX_W   = 8;
   localparam int unsigned DEF_WORD_W  = 96;
   localparam int unsigned DEF_ACC_W   = 4;
   localparam int unsigned DEF_ENTRIES = 256;
   localparam logic [7:0]  DEF_PREFIX  = 8'hA5;

   typedef enum logic [1:0] {
      LK_NONE   = 2'd0,
      LK_HIT    = 2'd1,
      LK_FOREIGN = 2'd2
   } lookup_kind_e;
endpackage

// File: rtl/wcw_decode.sv
module wcw_decode
   import wcw_pkg::*;
#(
   parameter int unsigned INSTR_W = DEF_INSTR_W,
   parameter int unsigned IDX_W   = DEF_IDX_W,
   parameter int unsigned ENTRIES = DEF_ENTRIES,
   parameter logic [INSTR_W-IDX_W-1:0] PREFIX = DEF_PREFIX
) (
   input  logic               instr_valid,
   input  logic [INSTR_W-1:0] instr,
   output lookup_kind_e       kind,
   output logic               hit,
   output logic [IDX_W-1:0]   idx
);
   localparam int unsigned PREFIX_W = INSTR_W - IDX_W;

   logic [PREFIX_W-1:0] pre_field;
   logic                pre_match;
   logic                in_range;

   assign pre_field = instr[INSTR_W-1:IDX_W];
   assign idx       = instr[IDX_W-1:0];
   assign pre_match = (pre_field == PREFIX);

   generate
      if (ENTRIES == (1 << IDX_W)) begin : g_full_range
         assign in_range = 1'b1;
      end else begin : g_part_range
         assign in_range = (32'(idx) < ENTRIES);
      end
   endgenerate

   always_comb begin
      if (!instr_valid)                kind = LK_NONE;
      else if (pre_match && in_range)  kind = LK_HIT;
      else                             kind = LK_FOREIGN;
   end

   assign hit = (kind == LK_HIT);
endmodule

// File: rtl/wcw_table.sv
module wcw_table
   import wcw_pkg::*;
#(
   parameter int unsigned IDX_W   = DEF_IDX_W,
   parameter int unsigned WORD_W  = DEF_WORD_W,
   parameter int unsigned ENTRIES = DEF_ENTRIES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [WORD_W-1:0] rd_data
);
   localparam int unsigned AW = $clog2(ENTRIES);

   logic [WORD_W-1:0] mem [ENTRIES];
   logic              wr_ok;

   generate
      if (ENTRIES == (1 << IDX_W)) begin : g_wr_full
         assign wr_ok = wr_en;
      end else begin : g_wr_part
         assign wr_ok = wr_en && (32'(wr_idx) < ENTRIES);
      end
   endgenerate

   // Storage has no reset; the write port works at all times.
   always_ff @(posedge clk) begin
      if (wr_ok) mem[wr_idx[AW-1:0]] <= wr_data;
   end

   // Registered read samples the array before this edge's write lands.
   always_ff @(posedge clk) begin
      if (!rst_n)     rd_data <= '0;
      else if (rd_en) rd_data <= mem[rd_idx[AW-1:0]];
   end

   AST_WRITE_THEN_READ: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(wr_ok) && rd_en && rd_idx == $past(wr_idx)) |=> (rd_data == $past(wr_data, 2))) // R7
      else $error("write not visible to following lookup");
endmodule

// File: rtl/wcw_expander.sv
module wcw_expander
   import wcw_pkg::*;
#(
   parameter int unsigned INSTR_W = DEF_INSTR_W,
   parameter int unsigned IDX_W   = DEF_IDX_W,
   parameter int unsigned WORD_W  = DEF_WORD_W,
   parameter int unsigned ACC_W   = DEF_ACC_W,
   parameter int unsigned ENTRIES = DEF_ENTRIES,
   parameter logic [INSTR_W-IDX_W-1:0] PREFIX = DEF_PREFIX
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               instr_valid,
   input  logic [INSTR_W-1:0] instr,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [WORD_W-1:0]  wr_data,
   output logic               ctl_valid,
   output logic [WORD_W-1:0]  ctl_word,
   output logic [ACC_W-1:0]   acc_ctl
);
   localparam int unsigned ACC_LSB = WORD_W - ACC_W;

   generate
      if (IDX_W >= INSTR_W) begin : g_bad_idx
         $error("index must leave room for a prefix");
      end
      if (ENTRIES < 2 || ENTRIES > (1 << IDX_W)) begin : g_bad_depth
         $error("table depth out of range for index width");
      end
      if (ACC_W == 0 || ACC_W >= WORD_W) begin : g_bad_acc
         $error("accelerator field must fit inside the entry");
      end
   endgenerate

   lookup_kind_e     kind;
   logic             hit;
   logic [IDX_W-1:0] idx;
   logic             valid_q;

   wcw_decode #(
      .INSTR_W (INSTR_W),
      .IDX_W   (IDX_W),
      .ENTRIES (ENTRIES),
      .PREFIX  (PREFIX)
   ) u_decode (
      .instr_valid (instr_valid),
      .instr       (instr),
      .kind        (kind),
      .hit         (hit),
      .idx         (idx)
   );

   wcw_table #(
      .IDX_W   (IDX_W),
      .WORD_W  (WORD_W),
      .ENTRIES (ENTRIES)
   ) u_table (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_data (wr_data),
      .rd_en   (hit),
      .rd_idx  (idx),
      .rd_data (ctl_word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) valid_q <= 1'b0;
      else        valid_q <= hit;
   end

   assign ctl_valid = valid_q;
   assign acc_ctl   = ctl_word[WORD_W-1:ACC_LSB];

   AST_HIT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && instr[INSTR_W-1:IDX_W] == PREFIX) |=> ctl_valid) // R2
      else $error("expansion instruction gave no valid output");

   AST_MISS_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
      (!instr_valid || instr[INSTR_W-1:IDX_W] != PREFIX) |=> !ctl_valid) // R3
      else $error("non-expansion instruction raised valid");

   AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_valid && $past(rst_n)) |-> $stable(ctl_word)) // R9
      else $error("control word moved without a lookup");

   AST_HOLD_ACC: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_valid && $past(rst_n)) |-> $stable(acc_ctl)) // R9
      else $error("accelerator field moved without a lookup");
endmodule

// File: tb/wcw_expander_tb.sv
module wcw_expander_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        instr_valid = 1'b0;
   logic [15:0] instr = '0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_idx = '0;
   logic [95:0] wr_data = '0;
   logic        ctl_valid;
   logic [95:0] ctl_word;
   logic [3:0]  acc_ctl;

   int unsigned n_tests = 0;
   int unsigned n_fail  = 0;
   bit          done = 1'b0;
   logic [95:0] model [256];

   always #5 clk = ~clk;

   wcw_expander u_dut (
      .clk (clk), .rst_n (rst_n), .instr_valid (instr_valid), .instr (instr),
      .wr_en (wr_en), .wr_idx (wr_idx), .wr_data (wr_data),
      .ctl_valid (ctl_valid), .ctl_word (ctl_word), .acc_ctl (acc_ctl)
   );

   function automatic logic [95:0] pat(input int i, input int salt);
      logic [31:0] a, b, c;
      a = 32'(i) * 32'h0101_0101 ^ 32'(salt) * 32'h9E37_79B9;
      b = ~(32'(i) << 3) + 32'(salt);
      c = 32'(i) + 32'(salt) * 32'h0001_0003;
      return {a, b, c};
   endfunction

   task automatic chk(input string req, input logic [95:0] act, input logic [95:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Inputs change at the falling edge; outputs checked at the next falling edge.
   task automatic drive(input logic iv, input logic [15:0] ins,
                        input logic we, input logic [7:0] wi, input logic [95:0] wd);
      instr_valid = iv; instr = ins; wr_en = we; wr_idx = wi; wr_data = wd;
      if (we) model[wi] = wd;
      @(negedge clk);
      instr_valid = 1'b0; wr_en = 1'b0;
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      chk("R1 valid in reset", 96'(ctl_valid), 96'd0);
      chk("R1 word in reset", ctl_word, 96'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 valid after reset", 96'(ctl_valid), 96'd0);
      chk("R1 acc after reset", 96'(acc_ctl), 96'd0);
   endtask

   task automatic t_load_lookup();
      for (int i = 0; i < 256; i++) drive(1'b0, 16'h0, 1'b1, 8'(i), pat(i, 1));
      for (int i = 0; i < 256; i += 37) begin
         drive(1'b1, {8'hA5, 8'(i)}, 1'b0, 8'h0, 96'h0);
         chk("R2 valid on hit", 96'(ctl_valid), 96'd1);
         chk("R4 word", ctl_word, model[i]);
         chk("R5 acc field", 96'(acc_ctl), 96'(model[i][95:92]));
      end
      drive(1'b1, 16'hA5FF, 1'b0, 8'h0, 96'h0);
      chk("R4 last index", ctl_word, model[255]);
   endtask

   task automatic t_back_to_back();
      instr_valid = 1'b1; instr = 16'hA503;
      @(negedge clk);
      chk("R4 b2b first", ctl_word, model[3]);
      instr = 16'hA580;
      @(negedge clk);
      instr_valid = 1'b0;
      chk("R4 b2b second", ctl_word, model[8'h80]);
      chk("R2 b2b valid", 96'(ctl_valid), 96'd1);
   endtask

   task automatic t_foreign();
      logic [95:0] held;
      drive(1'b1, 16'hA511, 1'b0, 8'h0, 96'h0);
      held = ctl_word;
      drive(1'b1, 16'hA411, 1'b0, 8'h0, 96'h0);
      chk("R3 other prefix", 96'(ctl_valid), 96'd0);
      chk("R9 word held", ctl_word, held);
      drive(1'b0, 16'hA522, 1'b0, 8'h0, 96'h0);
      chk("R3 strobe low", 96'(ctl_valid), 96'd0);
      drive(1'b0, 16'h0, 1'b1, 8'h11, pat(17, 9));
      chk("R9 held over write", ctl_word, held);
      chk("R9 acc held", 96'(acc_ctl), 96'(held[95:92]));
   endtask

   task automatic t_rbw();
      logic [95:0] old_v;
      old_v = model[8'h42];
      drive(1'b1, 16'hA542, 1'b1, 8'h42, pat(66, 7));
      chk("R6 read before write", ctl_word, old_v);
      drive(1'b1, 16'hA542, 1'b0, 8'h0, 96'h0);
      chk("R7 new entry visible", ctl_word, model[8'h42]);
   endtask

   task automatic t_neighbours();
      drive(1'b0, 16'h0, 1'b1, 8'h10, pat(16, 5));
      drive(1'b1, 16'hA510, 1'b0, 8'h0, 96'h0);
      chk("R7 on-the-fly replace", ctl_word, model[8'h10]);
      drive(1'b1, 16'hA50F, 1'b0, 8'h0, 96'h0);
      chk("R8 lower neighbour", ctl_word, pat(15, 1));
      drive(1'b1, 16'hA511, 1'b0, 8'h0, 96'h0);
      chk("R8 upper neighbour", ctl_word, model[8'h11]);
   endtask

   initial begin
      t_reset();
      t_load_lookup();
      t_back_to_back();
      t_foreign();
      t_rbw();
      t_neighbours();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule